// File: doc/BRIEF.md
# Serial Flash Command Gatekeeper

This block is the control front end of a serial NOR flash slave that answers on an SPI bus. It watches each chip-select frame, counts its serial clocks, and takes the instruction byte that an upstream shifter has already captured. It then decides whether that instruction runs, is dropped, or is discarded. It holds the write-enable latch, the write-in-progress flag and the deep power-down lockout, and it reports whether the device is active or idle. The memory array, the shifting of address and data, and the decoding of protected regions are all outside it.

Instructions that change stored data run only when three conditions hold: the write-enable latch is set, the frame held a whole number of bytes when chip select rose, and no internal cycle is running. Once such an instruction is accepted, the block raises the busy flag for a programmable number of clocks. The array side can end that cycle early with a done pulse. When the cycle ends, the busy flag and the write-enable latch both clear. A power-down instruction locks out every instruction except the release instruction. Reads are granted when the instruction byte arrives. Every other instruction is granted on the rising edge of chip select.

Top module: `flash_cmd_gate`

## Requirements
- R1: After a synchronous reset, status bit 1 (write-enable latch) and status bit 0 (busy) read 0, the power-down flag is 0, the active flag is 0 and no execute strobe is issued.
- R2: On the rising edge of chip select, a frame whose opcode is 06h sets status bit 1 and a frame whose opcode is 04h clears it. Both are reported with an execute strobe.
- R3: A modify opcode (01h, 42h, 02h, A2h, 32h, 20h, D8h, C7h) is accepted under three conditions: the latch is 1, the frame clock count is a multiple of 8 when chip select rises, and the device is idle. When accepted, the block gives an execute strobe carrying the opcode and sets status bit 0 at that edge.
- R4: A modify opcode that arrives while the latch is 0 gives no execute strobe and leaves both status bits unchanged.
- R5: A modify opcode in a frame whose clock count is not a multiple of 8 is discarded: there is no strobe, busy stays 0 and the latch stays 1.
- R6: Once set, busy reads 1 for exactly cyc_len clocks. It then clears, and the latch clears in the same cycle.
- R7: A cyc_done pulse while busy ends the cycle in the next clock and clears the latch.
- R8: While busy, every instruction except 05h is ignored: the latch does not change and no strobe is issued. An 05h opcode still gives a strobe when its byte is decoded.
- R9: Opcode B9h sets the power-down flag. From then on every instruction is ignored (including 05h, 06h and the modify opcodes) until opcode ABh clears the flag.
- R10: The active flag goes to 1 the clock after chip select falls, unless the device is in power-down. It returns to 0 the clock after chip select rises, unless a cycle is busy, in which case it stays 1 until busy clears.
- R11: Any opcode outside the listed ones (for example 03h) is treated as a read. When idle, it gives an execute strobe as soon as its byte is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low while a frame is open |
| sclk_stb | input | 1 | One-clock pulse for each serial clock seen in the frame |
| op_stb | input | 1 | Pulse when the instruction byte has been captured |
| op_code | input | 8 | Captured instruction byte |
| cyc_done | input | 1 | Array reports its internal cycle finished |
| cyc_len | input | CYC_W | Internal cycle length in clocks |
| stat_o | output | 8 | Status: bit 0 busy, bit 1 write-enable latch, others 0 |
| exec_stb | output | 1 | One-clock strobe for a granted instruction |
| exec_code | output | 8 | Opcode of the last granted instruction |
| pwr_active | output | 1 | Device in active mode |
| pwr_dp | output | 1 | Device in deep power-down |

## Verification
The bench targets frames with a ragged bit count on a modify opcode. A design that checked only the byte count, or checked at the instruction byte instead of at chip-select rise, would start a program cycle that should have been discarded. It measures the busy window to the exact clock, so an off-by-one load of the cycle counter shows up at once. It also sends latch and status-read commands in the middle of a busy cycle and in power-down: a gate that skipped either lockout would let the latch move or issue a strobe there. Random frame mixes, with the latch state tracked by a bench model, catch a latch that fails to clear on completion.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;
  typedef enum logic [2:0] {
    CL_READ,
    CL_WREN,
    CL_WRDI,
    CL_RDSR,
    CL_DP,
    CL_RES,
    CL_MODIFY
  } op_cls_e;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_DP   = 8'hB9;
  localparam logic [7:0] OPC_RES  = 8'hAB;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_POTP = 8'h42;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_DPP  = 8'hA2;
  localparam logic [7:0] OPC_QPP  = 8'h32;
  localparam logic [7:0] OPC_SE   = 8'h20;
  localparam logic [7:0] OPC_BE   = 8'hD8;
  localparam logic [7:0] OPC_CE   = 8'hC7;

  localparam int STAT_WIP = 0;
  localparam int STAT_WEL = 1;
endpackage

// File: rtl/flash_op_class.sv
module flash_op_class
  import flash_gate_pkg::*;
(
  input  logic [7:0] code_i,
  output op_cls_e    cls_o
);
  always_comb begin
    case (code_i)
      OPC_WREN: cls_o = CL_WREN;
      OPC_WRDI: cls_o = CL_WRDI;
      OPC_RDSR: cls_o = CL_RDSR;
      OPC_DP:   cls_o = CL_DP;
      OPC_RES:  cls_o = CL_RES;
      OPC_WRSR, OPC_POTP, OPC_PP, OPC_DPP,
      OPC_QPP, OPC_SE, OPC_BE, OPC_CE: cls_o = CL_MODIFY;
      default:  cls_o = CL_READ;
    endcase
  end
endmodule

// File: rtl/flash_bit_ctr.sv
module flash_bit_ctr #(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk_stb,
  output logic aligned_o
);
  localparam int CW = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_BITS - 1);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      phase_q <= '0;
    end else if (sclk_stb) begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign aligned_o = (phase_q == '0);
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             abort_i,
  input  logic [CYC_W-1:0] len_i,
  output logic             fire_o
);
  logic [CYC_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= (len_i == '0) ? CYC_W'(1) : len_i;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign fire_o = (left_q == CYC_W'(1));
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
  import flash_gate_pkg::*;
#(
  parameter int CYC_W     = 16,
  parameter int BYTE_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk_stb,
  input  logic             op_stb,
  input  logic [7:0]       op_code,
  input  logic             cyc_done,
  input  logic [CYC_W-1:0] cyc_len,
  output logic [7:0]       stat_o,
  output logic             exec_stb,
  output logic [7:0]       exec_code,
  output logic             pwr_active,
  output logic             pwr_dp
);
  op_cls_e    cls_now, cls_q;
  logic [7:0] code_q;
  logic       have_q, cs_q;
  logic       wel_q, wip_q, dp_q;
  logic       wel_d, wip_d, dp_d;
  logic       ex_d;
  logic [7:0] exc_d;
  logic       aligned, fire, load;
  logic       frame_end, cyc_end;

  flash_op_class u_cls (
    .code_i (op_code),
    .cls_o  (cls_now)
  );

  flash_bit_ctr #(.BYTE_BITS(BYTE_BITS)) u_bits (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk_stb  (sclk_stb),
    .aligned_o (aligned)
  );

  flash_busy_timer #(.CYC_W(CYC_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .abort_i (cyc_done),
    .len_i   (cyc_len),
    .fire_o  (fire)
  );

  assign frame_end = cs_n & ~cs_q;
  assign cyc_end   = wip_q & (fire | cyc_done);

  always_comb begin
    wel_d = wel_q;
    wip_d = wip_q;
    dp_d  = dp_q;
    ex_d  = 1'b0;
    exc_d = exec_code;
    load  = 1'b0;
    if (cyc_end) begin
      wip_d = 1'b0;
      wel_d = 1'b0;
    end
    if (op_stb && !cs_n && !have_q && !dp_q) begin
      if (cls_now == CL_RDSR || (cls_now == CL_READ && !wip_q)) begin
        ex_d  = 1'b1;
        exc_d = op_code;
      end
    end
    if (frame_end && have_q) begin
      if (dp_q) begin
        if (cls_q == CL_RES) begin
          dp_d  = 1'b0;
          ex_d  = 1'b1;
          exc_d = code_q;
        end
      end else if (!wip_q) begin
        case (cls_q)
          CL_WREN: begin wel_d = 1'b1; ex_d = 1'b1; exc_d = code_q; end
          CL_WRDI: begin wel_d = 1'b0; ex_d = 1'b1; exc_d = code_q; end
          CL_DP:   begin dp_d  = 1'b1; ex_d = 1'b1; exc_d = code_q; end
          CL_RES:  begin ex_d  = 1'b1; exc_d = code_q; end
          CL_MODIFY: begin
            if (wel_q && aligned) begin
              wip_d = 1'b1;
              load  = 1'b1;
              ex_d  = 1'b1;
              exc_d = code_q;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q       <= 1'b1;
      have_q     <= 1'b0;
      cls_q      <= CL_READ;
      code_q     <= '0;
      wel_q      <= 1'b0;
      wip_q      <= 1'b0;
      dp_q       <= 1'b0;
      exec_stb   <= 1'b0;
      exec_code  <= '0;
      pwr_active <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        have_q <= 1'b0;
      end else if (op_stb && !have_q) begin
        have_q <= 1'b1;
        cls_q  <= cls_now;
        code_q <= op_code;
      end
      wel_q      <= wel_d;
      wip_q      <= wip_d;
      dp_q       <= dp_d;
      exec_stb   <= ex_d;
      exec_code  <= exc_d;
      pwr_active <= !dp_d && (!cs_n || wip_d);
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o[STAT_WIP] = wip_q;
    stat_o[STAT_WEL] = wel_q;
  end
  assign pwr_dp = dp_q;
endmodule

// File: rtl/flash_cmd_gate_chk.sv
module flash_cmd_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       wip,
  input logic       wel,
  input logic       exec_stb,
  input logic [7:0] exec_code,
  input logic       pwr_active,
  input logic       pwr_dp
);
  AST_WIP_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(wel)); // R3

  AST_DONE_DROPS_WEL: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !wel); // R6

  AST_BUSY_ONLY_RDSR: assert property (@(posedge clk) disable iff (rst)
    (wip && $past(wip) && exec_stb) |-> (exec_code == 8'h05)); // R8

  AST_DP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (pwr_dp && $past(pwr_dp)) |-> !exec_stb); // R9

  AST_DP_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(pwr_dp && wip)); // R9

  AST_DP_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !(pwr_dp && pwr_active)); // R10

  AST_BUSY_IS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    wip |-> pwr_active); // R10
endmodule

bind flash_cmd_gate flash_cmd_gate_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .wip        (stat_o[0]),
  .wel        (stat_o[1]),
  .exec_stb   (exec_stb),
  .exec_code  (exec_code),
  .pwr_active (pwr_active),
  .pwr_dp     (pwr_dp)
);

// File: tb/test_flash_cmd_gate.sv
module test_flash_cmd_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk_stb = 1'b0;
  logic        op_stb = 1'b0;
  logic [7:0]  op_code = '0;
  logic        cyc_done = 1'b0;
  logic [15:0] cyc_len = 16'd6;
  logic [7:0]  stat_o;
  logic        exec_stb;
  logic [7:0]  exec_code;
  logic        pwr_active;
  logic        pwr_dp;

  int total = 0;
  int bad = 0;
  int n_exec = 0;
  logic [7:0] last_code = '0;
  bit done_flag = 0;

  flash_cmd_gate i_flash_cmd_gate (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk_stb(sclk_stb), .op_stb(op_stb),
    .op_code(op_code), .cyc_done(cyc_done), .cyc_len(cyc_len),
    .stat_o(stat_o), .exec_stb(exec_stb), .exec_code(exec_code),
    .pwr_active(pwr_active), .pwr_dp(pwr_dp)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (exec_stb) begin
      n_exec++;
      last_code = exec_code;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      sclk_stb = 1'b1;
      tick();
      sclk_stb = 1'b0;
      tick();
    end
  endtask

  task automatic open_frame(input logic [7:0] op);
    cs_n = 1'b0;
    tick();
    bits(8);
    op_code = op;
    op_stb = 1'b1;
    tick();
    op_stb = 1'b0;
  endtask

  task automatic close_frame();
    cs_n = 1'b1;
    tick();
  endtask

  task automatic frame(input logic [7:0] op, input int extra);
    open_frame(op);
    bits(extra);
    close_frame();
  endtask

  function automatic bit f_modify(input logic [7:0] op);
    return op inside {8'h01, 8'h42, 8'h02, 8'hA2, 8'h32, 8'h20, 8'hD8, 8'hC7};
  endfunction

  function automatic bit f_grant(input logic [7:0] op, input bit wel, input bit dp, input int extra);
    if (dp) return op == 8'hAB;
    if (f_modify(op)) return wel && (extra % 8 == 0);
    return 1'b1;
  endfunction

  initial begin
    #(150000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    if (!done_flag) $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0;
    bit m_wel, m_dp;
    process::self().srandom(32'd1234);
    void'($urandom(32'd1234));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 wel", stat_o[1], 0);
    chk("R1 wip", stat_o[0], 0);
    chk("R1 dp", pwr_dp, 0);
    chk("R1 active", pwr_active, 0);
    chk("R1 strobes", n_exec, 0);

    // R10 active on chip select low, idle when it rises
    cs_n = 1'b0; tick();
    chk("R10 active low cs", pwr_active, 1);
    cs_n = 1'b1; tick();
    chk("R10 idle high cs", pwr_active, 0);

    // R2 latch set and clear
    e0 = n_exec;
    frame(8'h06, 0);
    chk("R2 wren sets", stat_o[1], 1);
    chk("R2 wren strobe", n_exec - e0, 1);
    frame(8'h04, 0);
    chk("R2 wrdi clears", stat_o[1], 0);
    chk("R2 wrdi code", last_code, 8'h04);

    // R4 modify without latch
    e0 = n_exec;
    frame(8'h02, 32);
    chk("R4 no strobe", n_exec - e0, 0);
    chk("R4 wip", stat_o[0], 0);

    // R5 ragged frame
    frame(8'h06, 0);
    e0 = n_exec;
    frame(8'h02, 13);
    chk("R5 no strobe", n_exec - e0, 0);
    chk("R5 wip", stat_o[0], 0);
    chk("R5 wel kept", stat_o[1], 1);

    // R3 and R6 exact busy window
    cyc_len = 16'd6;
    e0 = n_exec;
    frame(8'h20, 24);
    chk("R3 strobe", n_exec - e0, 1);
    chk("R3 code", last_code, 8'h20);
    chk("R3 wip set", stat_o[0], 1);
    repeat (5) tick();
    chk("R6 wip still", stat_o[0], 1);
    chk("R10 active while busy", pwr_active, 1);
    tick();
    chk("R6 wip clear", stat_o[0], 0);
    chk("R6 wel clear", stat_o[1], 0);
    chk("R10 idle after busy", pwr_active, 0);

    // R8 busy lockout
    cyc_len = 16'd400;
    frame(8'h06, 0);
    frame(8'h02, 32);
    chk("R8 busy", stat_o[0], 1);
    e0 = n_exec;
    frame(8'h04, 0);
    chk("R8 wrdi ignored", stat_o[1], 1);
    frame(8'h03, 24);
    chk("R8 read ignored", n_exec - e0, 0);
    frame(8'h05, 8);
    chk("R8 rdsr served", n_exec - e0, 1);
    chk("R8 rdsr code", last_code, 8'h05);

    // R7 early completion
    cyc_done = 1'b1; tick(); cyc_done = 1'b0;
    chk("R7 wip clear", stat_o[0], 0);
    chk("R7 wel clear", stat_o[1], 0);

    // R11 read granted at decode
    e0 = n_exec;
    open_frame(8'h03);
    tick();
    chk("R11 read strobe at decode", n_exec - e0, 1);
    bits(24);
    close_frame();
    chk("R11 single strobe", n_exec - e0, 1);

    // R9 power-down lockout
    frame(8'hB9, 0);
    chk("R9 dp set", pwr_dp, 1);
    chk("R9 not active", pwr_active, 0);
    e0 = n_exec;
    frame(8'h05, 8);
    frame(8'h06, 0);
    chk("R9 ignored strobes", n_exec - e0, 0);
    chk("R9 wel held", stat_o[1], 0);
    frame(8'hAB, 0);
    chk("R9 dp cleared", pwr_dp, 0);
    chk("R9 release strobe", n_exec - e0, 1);

    // random frame mix against bench model (R2 R3 R5 R6 R9 R11)
    cyc_len = 16'd5;
    m_wel = 0;
    m_dp = 0;
    for (int it = 0; it < 120; it++) begin
      logic [7:0] ops [14] = '{8'h06, 8'h04, 8'h05, 8'h03, 8'h02, 8'hA2, 8'h32,
                                 8'h20, 8'hD8, 8'hC7, 8'h01, 8'h42, 8'hB9, 8'hAB};
      logic [7:0] op;
      int extra;
      bit g;
      op = ($urandom % 3 == 0) ? 8'h06 : ops[$urandom % 14];
      extra = 8 * ($urandom % 3);
      if ($urandom % 3 == 0) extra += 1 + ($urandom % 7);
      g = f_grant(op, m_wel, m_dp, extra);
      e0 = n_exec;
      frame(op, extra);
      chk("R3 random strobe", n_exec - e0, g);
      if (g) chk("R3 random code", last_code, op);
      if (g && !m_dp) begin
        if (op == 8'h06) m_wel = 1;
        if (op == 8'h04) m_wel = 0;
        if (op == 8'hB9) m_dp = 1;
      end else if (g && op == 8'hAB) begin
        m_dp = 0;
      end
      chk("R2 random wel", stat_o[1], m_wel);
      chk("R9 random dp", pwr_dp, m_dp);
      chk("R3 random wip", stat_o[0], g && f_modify(op));
      if (g && f_modify(op)) begin
        repeat (5) tick();
        m_wel = 0;
        chk("R6 random wip end", stat_o[0], 0);
        chk("R6 random wel end", stat_o[1], 0);
      end
    end

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule